// File: doc/BRIEF.md
# Protection Region Address Matcher

This block checks one memory transaction against a table of protection entries. It sits in front of a shared memory target. Each entry describes one physical region and the accesses that region allows. The block reports, for every entry, whether the transaction address falls inside that entry's region. It also reports whether the requested kind of access is granted there. Grouping entries into domains, choosing an entry by priority, and raising a bus error are left to the logic that consumes the two vectors.

Each entry holds three things:
- a stored address word, which is the byte address shifted right by two;
- a two-bit region mode;
- a three-bit permission field.

The region mode selects one of four behaviours:
- off;
- a single aligned four-byte word;
- a naturally aligned power-of-two block, whose size comes from the trailing ones of the stored word;
- a half-open range, which takes its lower bound from the next lower-indexed entry.

The decode is combinational and the result vectors are registered. A request presented with its valid strobe on one rising edge has its answer on the outputs after that edge.

Top module: `protRegionMatcher`

## Requirements
- R1: After reset, `respValid`, `matchVec` and `permitVec` are all zero. `respValid` is high in the cycle after an edge at which `reqValid` was high, and low otherwise.
- R2: An entry in mode 0 (off) never sets its bit of `matchVec`, whatever its stored address is.
- R3: An entry in mode 2 (word) matches exactly when `reqAddr[ADDR_W-1:2]` equals its stored word. Byte offsets 0 to 3 within that word all match.
- R4: An entry in mode 3 (power-of-two) whose stored word has t trailing ones covers 2^(t+3) bytes. The block is aligned to its size and contains the byte address `stored<<2`. A stored word of all ones covers the whole address space.
- R5: An entry in mode 1 (range) matches when lower <= `reqAddr` < `stored<<2`. Here lower is `(stored word of entry i-1)<<2`, whatever mode entry i-1 is in. For entry 0, lower is zero.
- R6: A mode-1 entry whose lower bound is greater than or equal to its upper bound matches no address.
- R7: An entry's bit of `permitVec` is set only when its match bit is set and the permission bit for the requested access is set. The access codes are 0 = read, 1 = write and 2 = execute. They select permission bit 0, 1 and 2 respectively.
- R8: Access code 3 is reserved. It grants nothing: `permitVec` is all zero, while `matchVec` still reports the region hits.
- R9: At an edge where `reqValid` is low, `matchVec` and `permitVec` are loaded with zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A transaction is presented this cycle |
| reqAddr | input | ADDR_W | Physical byte address of the transaction |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| entryAddr | input | NUM_ENTRIES x (ADDR_W-2) | Stored address word of each entry (byte address >> 2) |
| entryMode | input | NUM_ENTRIES x 2 | Region mode of each entry: 0 off, 1 range, 2 word, 3 power-of-two |
| entryPerm | input | NUM_ENTRIES x 3 | Permissions of each entry: bit 0 read, bit 1 write, bit 2 execute |
| respValid | output | 1 | The result vectors hold the answer to the previous request |
| matchVec | output | NUM_ENTRIES | Per-entry region hit |
| permitVec | output | NUM_ENTRIES | Per-entry hit with the requested access allowed |

## Verification
Two things can hit the same address in the same cycle:
- a range entry, whose lower bound is the stored word of the entry below it;
- that lower entry, matching on its own in word or power-of-two mode.

The bench provokes this by placing a word entry at the start of a range entry's span and sending a request to that exact word. It also sends requests to the word just below the span and to the last word inside it. The behavioural model judges each bit independently, so both hits must appear together and each must carry its own permit bit. Random table contents kept in a small address window reach the same overlap repeatedly, together with empty ranges and off entries that donate a bound.

// File: rtl/prMatchPkg.sv
package prMatchPkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RANGE = 2'd1,
    MODE_WORD  = 2'd2,
    MODE_POW2  = 2'd3
  } regionMode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accessKind_e;

  localparam int PERM_READ_BIT  = 0;
  localparam int PERM_WRITE_BIT = 1;
  localparam int PERM_EXEC_BIT  = 2;
  localparam int PERM_W         = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // load fresh results
    logic flush;    // load zeros
  } pipeStrobe_t;

endpackage

// File: rtl/prRegionDecode.sv
module prRegionDecode
  import prMatchPkg::*;
#(
  parameter int WORD_W   = 30,
  parameter bit IS_FIRST = 1'b0
) (
  input  logic [WORD_W-1:0] addrWord,
  input  logic [WORD_W-1:0] selfWord,
  input  logic [WORD_W-1:0] prevWord,
  input  logic [1:0]        mode,
  output logic              hit
);

  localparam logic [WORD_W-1:0] WORD_ONE = WORD_W'(1);

  logic [WORD_W-1:0] lowerWord;
  logic [WORD_W-1:0] pow2Care;
  logic              rangeHit;
  logic              wordHit;
  logic              pow2Hit;

  // The first entry's range starts at zero; later entries borrow the neighbour's word.
  generate
    if (IS_FIRST) begin : gFirstLower
      logic unusedPrev;
      assign unusedPrev = ^prevWord;
      assign lowerWord  = '0;
    end else begin : gLaterLower
      assign lowerWord = prevWord;
    end
  endgenerate

  // selfWord ^ (selfWord+1) sets the trailing ones plus the next bit: the don't-care span.
  assign pow2Care = ~(selfWord ^ (selfWord + WORD_ONE));
  assign pow2Hit  = ((addrWord ^ selfWord) & pow2Care) == '0;
  assign wordHit  = (addrWord == selfWord);
  assign rangeHit = (addrWord >= lowerWord) && (addrWord < selfWord);

  always_comb begin
    case (regionMode_e'(mode))
      MODE_RANGE: hit = rangeHit;
      MODE_WORD:  hit = wordHit;
      MODE_POW2:  hit = pow2Hit;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/prMatchCtrl.sv
module prMatchCtrl
  import prMatchPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output pipeStrobe_t strobe,
  output logic        respValid
);

  always_comb begin
    strobe.capture = reqValid;
    strobe.flush   = ~reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

  // R1: response valid tracks the request one edge later.
  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  assert_resp_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

endmodule

// File: rtl/prMatchDatapath.sv
module prMatchDatapath
  import prMatchPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  pipeStrobe_t                           strobe,
  input  logic [ADDR_W-3:0]                     addrWord,
  input  logic [1:0]                            reqAccess,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-3:0]    entryAddr,
  input  logic [NUM_ENTRIES-1:0][1:0]           entryMode,
  input  logic [NUM_ENTRIES-1:0][PERM_W-1:0]    entryPerm,
  output logic [NUM_ENTRIES-1:0]                matchVec,
  output logic [NUM_ENTRIES-1:0]                permitVec
);

  localparam int WORD_W = ADDR_W - 2;

  logic [NUM_ENTRIES-1:0] hitNow;
  logic [NUM_ENTRIES-1:0] permitNow;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    logic [WORD_W-1:0] prevWord;
    logic              permBit;

    if (i == 0) begin : gPrevZero
      assign prevWord = '0;
    end else begin : gPrevLower
      assign prevWord = entryAddr[i-1];
    end

    prRegionDecode #(
      .WORD_W  (WORD_W),
      .IS_FIRST(i == 0)
    ) uDecode (
      .addrWord(addrWord),
      .selfWord(entryAddr[i]),
      .prevWord(prevWord),
      .mode    (entryMode[i]),
      .hit     (hitNow[i])
    );

    always_comb begin
      case (accessKind_e'(reqAccess))
        ACC_READ:  permBit = entryPerm[i][PERM_READ_BIT];
        ACC_WRITE: permBit = entryPerm[i][PERM_WRITE_BIT];
        ACC_EXEC:  permBit = entryPerm[i][PERM_EXEC_BIT];
        default:   permBit = 1'b0;
      endcase
    end

    assign permitNow[i] = hitNow[i] & permBit;

    // R2: an off entry stays silent.
    assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && entryMode[i] == 2'd0) |=> !matchVec[i]);
    // R3: exact word hit in word mode.
    assert_word_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && entryMode[i] == 2'd2 && addrWord == entryAddr[i]) |=> matchVec[i]);
    // R6: empty range never hits.
    assert_empty_range_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && entryMode[i] == 2'd1 && prevWord >= entryAddr[i]) |=> !matchVec[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVec  <= '0;
      permitVec <= '0;
    end else if (strobe.flush) begin
      matchVec  <= '0;
      permitVec <= '0;
    end else if (strobe.capture) begin
      matchVec  <= hitNow;
      permitVec <= permitNow;
    end
  end

  // R7: a grant never appears without a hit.
  assert_permit_needs_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (permitVec & ~matchVec) == '0);
  // R8: the reserved access code grants nothing.
  assert_rsvd_denied_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && reqAccess == 2'd3) |=> permitVec == '0);
  // R9: an idle edge clears both vectors.
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (matchVec == '0 && permitVec == '0));

endmodule

// File: rtl/protRegionMatcher.sv
module protRegionMatcher
  import prMatchPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [1:0]                          reqAccess,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-3:0]  entryAddr,
  input  logic [NUM_ENTRIES-1:0][1:0]         entryMode,
  input  logic [NUM_ENTRIES-1:0][2:0]         entryPerm,
  output logic                                respValid,
  output logic [NUM_ENTRIES-1:0]              matchVec,
  output logic [NUM_ENTRIES-1:0]              permitVec
);

  localparam int WORD_W = ADDR_W - 2;

  pipeStrobe_t       strobe;
  logic [WORD_W-1:0] addrWord;
  logic              unusedByteOffset;

  assign addrWord         = reqAddr[ADDR_W-1:2];
  assign unusedByteOffset = ^reqAddr[1:0];

  prMatchCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .respValid(respValid)
  );

  prMatchDatapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addrWord (addrWord),
    .reqAccess(reqAccess),
    .entryAddr(entryAddr),
    .entryMode(entryMode),
    .entryPerm(entryPerm),
    .matchVec (matchVec),
    .permitVec(permitVec)
  );

endmodule

// File: tb/tb_protRegionMatcher.sv
module tb_protRegionMatcher;

  localparam int N  = 8;
  localparam int AW = 32;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    reqValid = 1'b0;
  logic [AW-1:0]           reqAddr = '0;
  logic [1:0]              reqAccess = '0;
  logic [N-1:0][AW-3:0]    entryAddr = '0;
  logic [N-1:0][1:0]       entryMode = '0;
  logic [N-1:0][2:0]       entryPerm = '0;
  logic                    respValid;
  logic [N-1:0]            matchVec;
  logic [N-1:0]            permitVec;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R1";

  logic         expValid = 1'b0;
  logic [N-1:0] expMatch = '0;
  logic [N-1:0] expPermit = '0;

  always #4 clk = ~clk;  // 125 MHz

  protRegionMatcher #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqAccess(reqAccess), .entryAddr(entryAddr), .entryMode(entryMode),
    .entryPerm(entryPerm), .respValid(respValid), .matchVec(matchVec),
    .permitVec(permitVec)
  );

  // Behavioural reference: byte arithmetic on wide integers.
  function automatic bit refHit(int idx, longint unsigned addr);
    longint unsigned self, lo, size, base;
    int t;
    self = longint'(entryAddr[idx]) << 2;
    case (entryMode[idx])
      2'd2: return (addr >> 2) == longint'(entryAddr[idx]);
      2'd3: begin
        t = 0;
        while (t < AW - 2 && entryAddr[idx][t]) t++;
        if (t >= AW - 2) return 1'b1;
        size = 64'd1 << (t + 3);
        base = self & ~(size - 1);
        return (addr >= base) && (addr < base + size);
      end
      2'd1: begin
        lo = (idx == 0) ? 64'd0 : (longint'(entryAddr[idx-1]) << 2);
        return (addr >= lo) && (addr < self);
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic setEntry(int idx, logic [1:0] mode, longint unsigned byteAddr, logic [2:0] perm);
    entryMode[idx] = mode;
    entryAddr[idx] = AW'(byteAddr >> 2);
    entryPerm[idx] = perm;
  endtask

  task automatic setWordRaw(int idx, logic [1:0] mode, logic [AW-3:0] word, logic [2:0] perm);
    entryMode[idx] = mode;
    entryAddr[idx] = word;
    entryPerm[idx] = perm;
  endtask

  task automatic clearTable();
    entryAddr = '0;
    entryMode = '0;
    entryPerm = '0;
  endtask

  // Drive one request, predict the registered result, compare at the next falling edge.
  task automatic step(logic v, longint unsigned addr, logic [1:0] acc);
    reqValid  = v;
    reqAddr   = AW'(addr);
    reqAccess = acc;
    if (!rstN || !v) begin
      expValid  = 1'b0;
      expMatch  = '0;
      expPermit = '0;
    end else begin
      expValid = 1'b1;
      for (int i = 0; i < N; i++) begin
        expMatch[i]  = refHit(i, addr);
        expPermit[i] = expMatch[i] && (acc != 2'd3) && entryPerm[i][acc];
      end
    end
    @(negedge clk);
    compared++;
    if (respValid !== expValid) begin
      mismatched++;
      $display("FAIL %s respValid actual %b expected %b", curReq, respValid, expValid);
    end
    compared++;
    if (matchVec !== expMatch) begin
      mismatched++;
      $display("FAIL %s matchVec actual %b expected %b (addr %h)", curReq, matchVec, expMatch, addr);
    end
    compared++;
    if (permitVec !== expPermit) begin
      mismatched++;
      $display("FAIL %s permitVec actual %b expected %b (addr %h acc %0d)",
               curReq, permitVec, expPermit, addr, acc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state holds even while requests are offered.
    curReq = "R1";
    setEntry(0, 2'd2, 64'h40, 3'b111);
    step(1'b1, 64'h40, 2'd0);
    step(1'b1, 64'h40, 2'd0);
    rstN = 1'b1;
    step(1'b0, 64'h40, 2'd0);
    step(1'b1, 64'h40, 2'd0);
    step(1'b0, 64'h40, 2'd0);

    // R2: every entry off, addresses equal to stored words.
    curReq = "R2";
    clearTable();
    for (int i = 0; i < N; i++) setEntry(i, 2'd0, 64'h100 * (i + 1), 3'b111);
    step(1'b1, 64'h100, 2'd0);
    step(1'b1, 64'h300, 2'd1);
    step(1'b1, 64'h0, 2'd2);

    // R3: word mode edges.
    curReq = "R3";
    clearTable();
    setEntry(3, 2'd2, 64'h1000, 3'b001);
    step(1'b1, 64'hFFC, 2'd0);
    step(1'b1, 64'h1000, 2'd0);
    step(1'b1, 64'h1003, 2'd0);
    step(1'b1, 64'h1004, 2'd0);

    // R4: power-of-two blocks (8 bytes, 4 KiB, whole space).
    curReq = "R4";
    clearTable();
    setEntry(1, 2'd3, 64'h2000, 3'b011);
    setWordRaw(2, 2'd3, AW'((64'h10000 >> 2) | 64'h1FF), 3'b100);
    step(1'b1, 64'h1FFF, 2'd0);
    step(1'b1, 64'h2000, 2'd0);
    step(1'b1, 64'h2007, 2'd1);
    step(1'b1, 64'h2008, 2'd0);
    step(1'b1, 64'hFFFF, 2'd2);
    step(1'b1, 64'h10000, 2'd2);
    step(1'b1, 64'h10FFF, 2'd2);
    step(1'b1, 64'h11000, 2'd2);
    setWordRaw(5, 2'd3, '1, 3'b001);
    step(1'b1, 64'hFFFF_FFFC, 2'd0);
    step(1'b1, 64'h0, 2'd0);

    // R5: ranges, entry 0 from zero, bound borrowed from word and off neighbours.
    curReq = "R5";
    clearTable();
    setEntry(0, 2'd1, 64'h100, 3'b001);
    setEntry(1, 2'd2, 64'h400, 3'b010);
    setEntry(2, 2'd1, 64'h800, 3'b011);
    setEntry(3, 2'd0, 64'hC00, 3'b000);
    setEntry(4, 2'd1, 64'h1000, 3'b100);
    step(1'b1, 64'h0, 2'd0);
    step(1'b1, 64'hFF, 2'd0);
    step(1'b1, 64'h100, 2'd0);
    step(1'b1, 64'h3FC, 2'd1);
    step(1'b1, 64'h400, 2'd1);   // word entry and range entry hit together
    step(1'b1, 64'h7FF, 2'd0);
    step(1'b1, 64'h800, 2'd0);
    step(1'b1, 64'hBFF, 2'd2);
    step(1'b1, 64'hC00, 2'd2);
    step(1'b1, 64'hFFF, 2'd2);

    // R6: empty ranges (lower above and equal to upper).
    curReq = "R6";
    clearTable();
    setEntry(0, 2'd2, 64'h800, 3'b111);
    setEntry(1, 2'd1, 64'h400, 3'b111);
    setEntry(2, 2'd1, 64'h400, 3'b111);
    setEntry(6, 2'd1, 64'h0, 3'b111);
    step(1'b1, 64'h400, 2'd0);
    step(1'b1, 64'h600, 2'd0);
    step(1'b1, 64'h0, 2'd0);
    step(1'b1, 64'h3FC, 2'd0);

    // R7: each access kind against each single permission bit.
    curReq = "R7";
    clearTable();
    setEntry(0, 2'd2, 64'h20, 3'b001);
    setEntry(1, 2'd2, 64'h20, 3'b010);
    setEntry(2, 2'd2, 64'h20, 3'b100);
    setEntry(3, 2'd2, 64'h20, 3'b000);
    setEntry(4, 2'd2, 64'h24, 3'b111);
    for (int a = 0; a < 3; a++) step(1'b1, 64'h20, 2'(a));
    step(1'b1, 64'h24, 2'd1);

    // R8: reserved access code reports hits, grants nothing.
    curReq = "R8";
    step(1'b1, 64'h20, 2'd3);
    step(1'b1, 64'h24, 2'd3);

    // R9: idle edge between hits clears vectors.
    curReq = "R9";
    step(1'b1, 64'h20, 2'd0);
    step(1'b0, 64'h20, 2'd0);
    step(1'b1, 64'h24, 2'd2);
    step(1'b0, 64'h24, 2'd2);

    // Random tables in a small window, exercising overlaps and empty ranges.
    curReq = "R5/R4/R7 random";
    for (int blk = 0; blk < 40; blk++) begin
      for (int i = 0; i < N; i++) begin
        setWordRaw(i, 2'($urandom), AW'($urandom % 256), 3'($urandom));
      end
      for (int c = 0; c < 40; c++) begin
        step(($urandom % 5) != 0, 64'($urandom % 1024), 2'($urandom));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule